// File: doc/BRIEF.md
# Paired FIFO Status Register

This block sits between a bus master and a serial engine. It holds two queues. The transmit queue is filled from the bus side and drained by the engine whenever the engine needs its next data item. The receive queue is filled by the engine and drained by the bus side. One 32-bit status word reports the state of both queues in a single read:

- fill levels;
- empty and full indications;
- one sticky error flag per queue;
- the live level of the engine's interrupt line.

Each error flag holds its value until the bus master writes a 1 to that bit position. A write of 0 leaves a flag alone. The transmit error flag sets on two events: a push into a full transmit queue, and a data request from the engine while the transmit queue is empty.

Both queues are 16 entries deep and 8 bits wide by default. A push into a full queue is dropped, and so is a pop from an empty queue. A dropped operation changes neither the stored contents nor the level.

Top module: `paired_fifo_status`

## Requirements
- R1: After reset the status word reads 0x30: both queues are empty, both error flags are clear and every other bit is 0 while the interrupt input is low.
- R2: Bits 12:8 hold the transmit queue level (0 to 16). Bit 4 is 1 exactly when that level is 0. Bit 5 is 1 exactly when that level is below 16. Transmit data leaves in the order it entered, and `tx_pop_data` shows the oldest entry.
- R3: Bits 20:16 hold the receive queue level (0 to 16). Bit 6 is 1 exactly when that level is above 0. Bit 7 is 1 exactly when that level is 16. Receive data leaves in the order it entered, and `rx_pop_data` shows the oldest entry.
- R4: A push into a full queue is dropped. The level stays at 16, and the entries read out afterwards are the original 16 in their original order.
- R5: A pop from an empty queue is dropped, and the level stays at 0.
- R6: Bit 0 (transmit error) becomes 1 on the clock edge after a transmit push while the transmit queue is full.
- R7: Bit 0 becomes 1 on the clock edge after a transmit data request while the transmit queue is empty.
- R8: Bit 1 (receive error) becomes 1 on the clock edge after a receive push while the receive queue is full.
- R9: A status write with a 1 in bit 0 or bit 1 clears that flag on the next edge. A write with a 0 in that position leaves the flag unchanged. The flags change only through a write or an error event.
- R10: If an error event and a write of 1 to the same flag bit fall in the same cycle, the flag is 1 after the edge.
- R11: Bit 3 follows the `periph_irq` input combinationally, with no clock delay.
- R12: Bit 2, bits 15:13 and bits 31:21 always read 0. Writing 1s to them changes no bit of the status word.
- R13: A push and a pop in the same cycle on a queue that is neither empty nor full leave its level unchanged and deliver the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push_vld | input | 1 | Bus-side push into the transmit queue |
| tx_push_data | input | 8 | Data for the transmit push |
| tx_pop_req | input | 1 | Engine strobe: it needs the next transmit item |
| tx_pop_data | output | 8 | Oldest transmit entry |
| rx_push_vld | input | 1 | Engine push into the receive queue |
| rx_push_data | input | 8 | Data for the receive push |
| rx_pop_req | input | 1 | Bus-side pop from the receive queue |
| rx_pop_data | output | 8 | Oldest receive entry |
| periph_irq | input | 1 | Interrupt line of the engine |
| reg_wr_en | input | 1 | Write strobe for the status word |
| reg_wr_data | input | 32 | Write data; a 1 in bit 0 or bit 1 clears that flag |
| reg_rd_data | output | 32 | Current status word |

## Verification
The assertions assume that every input is a clean, synchronous level that is sampled once per clock edge. A push or pop strobe that stays high for several cycles therefore counts as several operations. The assertions also assume that reset is applied before the first operation. The bench changes inputs only on the falling clock edge, holds each strobe for exactly one cycle, and starts every sequence after reset has been released. This way each queue operation and each flag write lines up with exactly one rising edge.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int WORD_W = 32;

    // Status word bit positions (software decodes these)
    localparam int TX_ERR_BIT   = 0;
    localparam int RX_ERR_BIT   = 1;
    localparam int IRQ_BIT      = 3;
    localparam int TX_EMPTY_BIT = 4;
    localparam int TX_NFULL_BIT = 5;
    localparam int RX_NEMPT_BIT = 6;
    localparam int RX_FULL_BIT  = 7;
    localparam int TX_LVL_LSB   = 8;
    localparam int RX_LVL_LSB   = 16;
    localparam int LVL_FIELD_W  = 5;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             empty;
        logic             full;
    } fifo_flags_t;

    typedef struct packed {
        logic overflow;
        logic underflow;
    } fifo_evt_t;

    function automatic logic [LVL_FIELD_W-1:0] fit_level(input logic [LVL_W-1:0] lvl);
        logic [LVL_FIELD_W-1:0] r;
        r = LVL_FIELD_W'(lvl);
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input fifo_flags_t tx,
        input fifo_flags_t rx,
        input logic        tx_err,
        input logic        rx_err,
        input logic        irq
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[TX_ERR_BIT]   = tx_err;
        w[RX_ERR_BIT]   = rx_err;
        w[IRQ_BIT]      = irq;
        w[TX_EMPTY_BIT] = tx.empty;
        w[TX_NFULL_BIT] = ~tx.full;
        w[RX_NEMPT_BIT] = ~rx.empty;
        w[RX_FULL_BIT]  = rx.full;
        w[TX_LVL_LSB +: LVL_FIELD_W] = fit_level(tx.level);
        w[RX_LVL_LSB +: LVL_FIELD_W] = fit_level(rx.level);
        return w;
    endfunction

endpackage

// File: rtl/pfs_fifo.sv
module pfs_fifo
    import pfs_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int DEP = DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_vld,
    input  logic [W-1:0] push_data,
    input  logic         pop_req,
    output logic [W-1:0] head_data,
    output fifo_flags_t  flags,
    output fifo_evt_t    evt
);
    localparam int PTR_W = (DEP > 1) ? $clog2(DEP) : 1;
    localparam int CNT_W = $clog2(DEP + 1);

    logic [W-1:0]     mem [DEP];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             is_full, is_empty, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEP - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_full  = (count == CNT_W'(DEP));
    assign is_empty = (count == '0);
    assign push_ok  = push_vld && !is_full;
    assign pop_ok   = pop_req && !is_empty;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_data     = mem[rd_ptr];
    assign flags.level   = LVL_W'(count);
    assign flags.empty   = is_empty;
    assign flags.full    = is_full;
    assign evt.overflow  = push_vld && is_full;
    assign evt.underflow = pop_req && is_empty;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEP)) else $error("level above depth"); // R2
    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        (push_vld && is_full && !pop_req) |=> (count == CNT_W'(DEP))) else $error("full push changed level"); // R4
    AST_EMPTY_POP_DROP: assert property (@(posedge clk) disable iff (rst)
        (pop_req && is_empty && !push_vld) |=> (count == '0)) else $error("empty pop changed level"); // R5
    AST_PUSHPOP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (push_vld && pop_req && !is_full && !is_empty) |=> $stable(count)) else $error("push+pop moved level"); // R13

endmodule

// File: rtl/pfs_sticky_flag.sv
module pfs_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag) else $error("event did not set flag"); // R10
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag) else $error("flag dropped without clear"); // R9
    AST_FLAG_NO_SPONT: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set_evt) |=> !flag) else $error("flag rose without event"); // R9

endmodule

// File: rtl/paired_fifo_status.sv
module paired_fifo_status
    import pfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_push_vld,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop_req,
    output logic [DATA_W-1:0] tx_pop_data,
    input  logic              rx_push_vld,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop_req,
    output logic [DATA_W-1:0] rx_pop_data,
    input  logic              periph_irq,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic [WORD_W-1:0] reg_rd_data
);
    fifo_flags_t tx_fl, rx_fl;
    fifo_evt_t   tx_ev, rx_ev;
    logic        tx_err, rx_err;
    logic        tx_err_set, rx_err_set;
    logic        rsvd_wr_unused;
    logic        rx_underflow_unused;

    pfs_fifo #(.W(DATA_W), .DEP(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push_vld(tx_push_vld), .push_data(tx_push_data),
        .pop_req(tx_pop_req), .head_data(tx_pop_data),
        .flags(tx_fl), .evt(tx_ev)
    );

    pfs_fifo #(.W(DATA_W), .DEP(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push_vld(rx_push_vld), .push_data(rx_push_data),
        .pop_req(rx_pop_req), .head_data(rx_pop_data),
        .flags(rx_fl), .evt(rx_ev)
    );

    // Transmit errors cover both directions; receive errors only overflow
    assign tx_err_set          = tx_ev.overflow | tx_ev.underflow;
    assign rx_err_set          = rx_ev.overflow;
    assign rx_underflow_unused = rx_ev.underflow;
    assign rsvd_wr_unused      = ^{reg_wr_data[WORD_W-1:RX_ERR_BIT+1]};

    pfs_sticky_flag u_tx_err (
        .clk(clk), .rst(rst), .set_evt(tx_err_set),
        .clr_req(reg_wr_en && reg_wr_data[TX_ERR_BIT]), .flag(tx_err)
    );

    pfs_sticky_flag u_rx_err (
        .clk(clk), .rst(rst), .set_evt(rx_err_set),
        .clr_req(reg_wr_en && reg_wr_data[RX_ERR_BIT]), .flag(rx_err)
    );

    assign reg_rd_data = pack_status(tx_fl, rx_fl, tx_err, rx_err, periph_irq);

    AST_TX_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tx_push_vld && !reg_rd_data[TX_NFULL_BIT]) |=> reg_rd_data[TX_ERR_BIT]) else $error("tx overflow not flagged"); // R6
    AST_TX_UNF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tx_pop_req && reg_rd_data[TX_EMPTY_BIT]) |=> reg_rd_data[TX_ERR_BIT]) else $error("tx underflow not flagged"); // R7
    AST_RX_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rx_push_vld && reg_rd_data[RX_FULL_BIT]) |=> reg_rd_data[RX_ERR_BIT]) else $error("rx overflow not flagged"); // R8

endmodule

// File: tb/paired_fifo_status_tb_top.sv
module paired_fifo_status_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_push_vld = 0, tx_pop_req = 0, rx_push_vld = 0, rx_pop_req = 0;
    logic [7:0]  tx_push_data = 0, rx_push_data = 0;
    logic [7:0]  tx_pop_data, rx_pop_data;
    logic        periph_irq = 0, reg_wr_en = 0;
    logic [31:0] reg_wr_data = 0, reg_rd_data;

    int checks = 0, failures = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic m_txerr = 0, m_rxerr = 0;

    always #10 clk = ~clk;

    paired_fifo_status dut_i (
        .clk(clk), .rst(rst),
        .tx_push_vld(tx_push_vld), .tx_push_data(tx_push_data),
        .tx_pop_req(tx_pop_req), .tx_pop_data(tx_pop_data),
        .rx_push_vld(rx_push_vld), .rx_push_data(rx_push_data),
        .rx_pop_req(rx_pop_req), .rx_pop_data(rx_pop_data),
        .periph_irq(periph_irq), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    function automatic logic [31:0] expect_word();
        int t = txq.size();
        int r = rxq.size();
        logic [31:0] w = 0;
        w = w + m_txerr + 2 * m_rxerr + 8 * periph_irq;
        w = w + ((t == 0) ? 32'h10 : 0) + ((t != 16) ? 32'h20 : 0);
        w = w + ((r != 0) ? 32'h40 : 0) + ((r == 16) ? 32'h80 : 0);
        w = w + t * 256 + r * 65536;
        return w;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One clocked operation; inputs driven at negedge, status checked at next negedge
    task automatic op(input string req, input logic txp, input logic [7:0] txd, input logic txpop,
                      input logic rxp, input logic [7:0] rxd, input logic rxpop,
                      input logic wr, input logic [31:0] wd);
        logic tx_ev, rx_ev;
        tx_push_vld = txp; tx_push_data = txd; tx_pop_req = txpop;
        rx_push_vld = rxp; rx_push_data = rxd; rx_pop_req = rxpop;
        reg_wr_en = wr; reg_wr_data = wd;
        #1;
        if (txpop && txq.size() > 0) check32({req, " tx head"}, {24'h0, tx_pop_data}, {24'h0, txq[0]});
        if (rxpop && rxq.size() > 0) check32({req, " rx head"}, {24'h0, rx_pop_data}, {24'h0, rxq[0]});
        tx_ev = (txp && txq.size() == 16) || (txpop && txq.size() == 0);
        rx_ev = rxp && rxq.size() == 16;
        if (tx_ev) m_txerr = 1; else if (wr && wd[0]) m_txerr = 0;
        if (rx_ev) m_rxerr = 1; else if (wr && wd[1]) m_rxerr = 0;
        begin
            bit tpush = txp && txq.size() < 16;
            bit tpop  = txpop && txq.size() > 0;
            bit rpush = rxp && rxq.size() < 16;
            bit rpop  = rxpop && rxq.size() > 0;
            if (tpop) void'(txq.pop_front());
            if (tpush) txq.push_back(txd);
            if (rpop) void'(rxq.pop_front());
            if (rpush) rxq.push_back(rxd);
        end
        @(negedge clk);
        tx_push_vld = 0; tx_pop_req = 0; rx_push_vld = 0; rx_pop_req = 0; reg_wr_en = 0;
        check32({req, " status"}, reg_rd_data, expect_word());
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check32("R1 reset", reg_rd_data, 32'h30);

        // R2/R4/R6: fill tx to 16, then overflow
        for (int i = 0; i < 17; i++) op(i < 16 ? "R2 fill" : "R4 R6 tx overflow",
                                        1, 8'(i * 7 + 3), 0, 0, 0, 0, 0, 0);
        // R9: write 0 keeps, write 1 clears
        op("R9 w0 keep", 0, 0, 0, 0, 0, 0, 1, 32'h0);
        op("R9 w1 clear", 0, 0, 0, 0, 0, 0, 1, 32'h1);
        // R2/R4 drain in order, then R5/R7 underflow
        for (int i = 0; i < 16; i++) op("R2 R4 drain", 0, 0, 1, 0, 0, 0, 0, 0);
        op("R5 R7 tx underflow", 0, 0, 1, 0, 0, 0, 0, 0);
        // R10: event and clear together
        op("R10 clr vs event", 0, 0, 1, 0, 0, 0, 1, 32'h1);
        op("R9 clear tx", 0, 0, 0, 0, 0, 0, 1, 32'h1);

        // R3/R8: rx fill, overflow, drain
        for (int i = 0; i < 17; i++) op(i < 16 ? "R3 fill" : "R4 R8 rx overflow",
                                        0, 0, 0, 1, 8'(8'hA5 ^ i), 0, 0, 0);
        op("R10 rx clr vs event", 0, 0, 0, 1, 8'h11, 0, 1, 32'h2);
        op("R9 rx w0 keep", 0, 0, 0, 0, 0, 0, 1, 32'h1);
        op("R9 rx w1 clear", 0, 0, 0, 0, 0, 0, 1, 32'h2);
        for (int i = 0; i < 17; i++) op("R3 R5 drain", 0, 0, 0, 0, 0, 1, 0, 0);

        // R13: simultaneous push+pop at several levels on both queues
        for (int lvl = 1; lvl < 16; lvl += 4) begin
            while (txq.size() < lvl) op("R13 setup", 1, 8'(lvl + txq.size()), 0, 1, 8'(lvl * 3 + rxq.size()), 0, 0, 0);
            for (int k = 0; k < 3; k++)
                op("R13 push+pop", 1, 8'(lvl * 16 + k), 1, 1, 8'(lvl * 5 + k), 1, 0, 0);
        end
        // R13 corner: full with push+pop drops push, pops one
        while (txq.size() < 16) op("R13 setup full", 1, 8'(txq.size()), 0, 0, 0, 0, 0, 0);
        op("R4 full push+pop", 1, 8'hEE, 1, 0, 0, 0, 0, 0);
        op("R9 clear", 0, 0, 0, 0, 0, 0, 1, 32'h3);

        // R11: irq combinational
        periph_irq = 1; #1;
        check32("R11 irq high", reg_rd_data, expect_word());
        periph_irq = 0; #1;
        check32("R11 irq low", reg_rd_data, expect_word());

        // R12: reserved-bit writes ignored
        op("R12 rsvd write", 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFC);
        check32("R12 rsvd zero", reg_rd_data & 32'hFFE0_E004, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule